// File: doc/BRIEF.md
# Routed Interrupt Controller with Dispatch Selector

This block gathers 64 level-sensitive interrupt lines. Each line has its own routing word, reached through a small memory-mapped register port. Two routing bits in that word decide whether the line feeds the processor's normal interrupt output, its fast interrupt output, both, or neither. A read-only selector word is also provided. It reports whether any line routed to the normal interrupt is asserted and, if one is, the lowest-numbered such line. A handler can therefore find its work with one read.

The source lines first pass through a synchronizer chain, so they may be asynchronous to the clock. Both outputs and the selector are combinational functions of the synchronized lines and the stored routing words. A line stays pending for as long as it is high and routed. Software clears the cause at the line's origin, which lies outside this block.

The register port carries requests on a valid/ready channel and returns read data on a second valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read produces one response in the next cycle. That response holds its data until `rsp_ready` is seen high, and `req_ready` stays low while a response is waiting and not accepted. Writes produce no response.

Top module: `irc_top`

## Requirements
- R1: After reset every routing word is 0, `irq_out` and `fiq_out` are low, and the selector reads 0.
- R2: The routing word of line n is at byte offset 4*n (n = 0..63). Bit 5 is the normal-interrupt route and bit 6 is the fast-interrupt route. A read returns those two bits as written, and all other bits read 0.
- R3: `irq_out` is high exactly when some synchronized line is high and its bit 5 is set.
- R4: `fiq_out` is high exactly when some synchronized line is high and its bit 6 is set.
- R5: The selector at byte offset 0x104 has bit 6 set when some line with bit 5 set is high. In that case bits 5:0 give the lowest such line number. Lines routed only to the fast output never appear in it.
- R6: When no line routed to the normal output is high, the whole selector word reads 0.
- R7: Writes to the selector or to unmapped offsets change no state. Reads of unmapped offsets (for example 0x100 and 0x200) return 0.
- R8: A change on a source line reaches `irq_out`, `fiq_out` and the selector after exactly two clock edges. A routing write takes effect on the outputs right after the edge that accepts it.
- R9: A read response appears in the cycle after acceptance. It keeps `rsp_valid` and `rsp_rdata` stable while `rsp_ready` is low, and `req_ready` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 64 | Level interrupt lines, may be asynchronous |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset; the low two bits are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data consumed |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 1 | Normal processor interrupt |
| fiq_out | output | 1 | Fast processor interrupt |

## Verification
Changes on the source lines are applied at a falling edge. The outputs are sampled one rising edge later, where they must still show the old value, and again two rising edges later, where they must show the new value. A routing write is checked at the falling edge right after the rising edge that accepts it. Read data is due one edge after acceptance and is compared by a monitor at the falling edge on which `rsp_valid` and `rsp_ready` are both high. Before any selector read, the source lines are left stable for at least three edges, so the expected word can be computed from the bench's own model.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int NUM_SRC_DEF = 64;
  localparam int ADDR_W_DEF  = 12;
  localparam int DATA_W_DEF  = 32;
  localparam int IRQ_BIT     = 5;
  localparam int FIQ_BIT     = 6;
  localparam int SEL_OFFSET  = 'h104;

  typedef struct packed {
    logic fiq;
    logic irq;
  } route_t;
endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irc_cfg_bank.sv
module irc_cfg_bank
  import irc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ID_W-1:0]    widx,
  input  route_t             wroute,
  input  logic [ID_W-1:0]    ridx,
  output route_t             rroute,
  output logic [NUM_SRC-1:0] irq_en,
  output logic [NUM_SRC-1:0] fiq_en
);
  route_t regs [NUM_SRC];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= '0;
        else if (we && (widx == ID_W'(i))) regs[i] <= wroute;
      end
      assign irq_en[i] = regs[i].irq;
      assign fiq_en[i] = regs[i].fiq;
    end
  endgenerate

  assign rroute = regs[ridx];
endmodule

// File: rtl/irc_select.sv
module irc_select #(
  parameter int NUM_SRC = 64,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic [NUM_SRC-1:0] fiq_en,
  output logic               irq,
  output logic               fiq,
  output logic               pend,
  output logic [ID_W-1:0]    id
);
  logic [NUM_SRC-1:0] irq_act;
  logic [NUM_SRC-1:0] fiq_act;

  assign irq_act = src & irq_en;
  assign fiq_act = src & fiq_en;
  assign irq     = |irq_act;
  assign fiq     = |fiq_act;

  always_comb begin
    pend = 1'b0;
    id   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (irq_act[i]) begin
        pend = 1'b1;
        id   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irc_top.sv
module irc_top
  import irc_pkg::*;
#(
  parameter int NUM_SRC     = NUM_SRC_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int DATA_W      = DATA_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               irq_out,
  output logic               fiq_out
);
  localparam int ID_W   = $clog2(NUM_SRC);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] NSRC_WORD = WORD_W'(NUM_SRC);
  localparam logic [WORD_W-1:0] SEL_WORD  = WORD_W'(SEL_OFFSET / 4);

  logic [NUM_SRC-1:0] src_s;
  logic [NUM_SRC-1:0] irq_en;
  logic [NUM_SRC-1:0] fiq_en;
  logic [WORD_W-1:0]  word;
  logic               accept;
  logic               cfg_hit;
  logic               sel_hit;
  logic               cfg_we;
  route_t             wroute;
  route_t             rroute;
  logic               sel_pend;
  logic [ID_W-1:0]    sel_id;
  logic [DATA_W-1:0]  rd_mux;

  irc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(src_s)
  );

  assign word    = req_addr[ADDR_W-1:2];
  assign cfg_hit = (word < NSRC_WORD);
  assign sel_hit = (word == SEL_WORD);
  assign accept  = req_valid && req_ready;
  assign cfg_we  = accept && req_write && cfg_hit;
  assign wroute  = '{fiq: req_wdata[FIQ_BIT], irq: req_wdata[IRQ_BIT]};

  irc_cfg_bank #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(word[ID_W-1:0]),
    .wroute(wroute), .ridx(word[ID_W-1:0]), .rroute(rroute),
    .irq_en(irq_en), .fiq_en(fiq_en)
  );

  irc_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .src(src_s), .irq_en(irq_en), .fiq_en(fiq_en),
    .irq(irq_out), .fiq(fiq_out), .pend(sel_pend), .id(sel_id)
  );

  always_comb begin
    rd_mux = '0;
    if (cfg_hit) begin
      rd_mux[IRQ_BIT] = rroute.irq;
      rd_mux[FIQ_BIT] = rroute.fiq;
    end else if (sel_hit) begin
      rd_mux[ID_W]     = sel_pend;
      rd_mux[ID_W-1:0] = sel_id;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_s,
  input logic               irq_out,
  input logic               fiq_out,
  input logic               sel_pend,
  input logic [$clog2(NUM_SRC)-1:0] sel_id,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_rdata
);
  p_irq_needs_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|src_s));
  p_fiq_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> (|src_s));
  p_sel_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pend == irq_out);
  p_sel_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_pend |-> (sel_id == '0));
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_ready_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind irc_top irc_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_s(src_s), .irq_out(irq_out),
  .fiq_out(fiq_out), .sel_pend(sel_pend), .sel_id(sel_id),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata)
);

// File: tb/irc_top_tb.sv
module irc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq_out;
  logic        fiq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  m_route [64];

  always #10 clk = ~clk;

  irc_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_model();
    logic [31:0] v = '0;
    for (int i = 63; i >= 0; i--)
      if (src_in[i] && m_route[i][0]) v = 32'h40 | 32'(i);
    return v;
  endfunction

  function automatic logic irq_model();
    logic v = 1'b0;
    for (int i = 0; i < 64; i++) v |= src_in[i] & m_route[i][0];
    return v;
  endfunction

  function automatic logic fiq_model();
    logic v = 1'b0;
    for (int i = 0; i < 64; i++) v |= src_in[i] & m_route[i][1];
    return v;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    if (a[11:2] < 10'd64) m_route[a[7:2]] = {d[6], d[5]};
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_outs(string tag);
    check_eq({tag, " irq"}, 32'(irq_out), 32'(irq_model()));
    check_eq({tag, " fiq"}, 32'(fiq_out), 32'(fiq_model()));
  endtask

  // monitor: pops the scoreboard when a response is consumed
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        check_eq(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) m_route[i] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_eq("R1 irq after reset", 32'(irq_out), 32'd0);
    check_eq("R1 fiq after reset", 32'(fiq_out), 32'd0);
    bus_read(12'h000, 32'h0, "R1 cfg0 reset");
    bus_read(12'h0FC, 32'h0, "R1 cfg63 reset");
    bus_read(12'h104, 32'h0, "R1 selector reset");

    bus_write(12'h028, 32'h20);   // line 10 -> irq
    bus_write(12'h00C, 32'h40);   // line 3  -> fiq
    bus_write(12'h0A0, 32'h60);   // line 40 -> both
    bus_write(12'h0FC, 32'hFF);   // line 63 -> both, extra bits dropped
    bus_read(12'h028, 32'h20, "R2 cfg10 readback");
    bus_read(12'h00C, 32'h40, "R2 cfg3 readback");
    bus_read(12'h0FC, 32'h60, "R2 cfg63 only route bits");

    // R8 source latency
    @(negedge clk);
    src_in[10] = 1'b1;
    @(posedge clk); @(negedge clk);
    check_eq("R8 irq not yet after one edge", 32'(irq_out), 32'd0);
    @(posedge clk); @(negedge clk);
    check_eq("R8 irq after two edges", 32'(irq_out), 32'd1);
    check_outs("R3 R4 line10");
    bus_read(12'h104, sel_model(), "R5 selector line10");

    src_in[3] = 1'b1;
    settle();
    check_outs("R4 fiq-only line3");
    bus_read(12'h104, sel_model(), "R5 fiq-only excluded");

    src_in[40] = 1'b1;
    settle();
    bus_read(12'h104, 32'h4A, "R5 lowest of 10 and 40");
    src_in[10] = 1'b0;
    settle();
    bus_read(12'h104, 32'h68, "R5 line40 after 10 drops");
    src_in[63] = 1'b1;
    settle();
    bus_read(12'h104, sel_model(), "R5 40 beats 63");
    check_outs("R3 R4 multi");

    src_in[40] = 1'b0; src_in[63] = 1'b0;
    settle();
    check_outs("R3 R4 only fiq line");
    bus_read(12'h104, 32'h0, "R6 selector idle");

    // R8 routing write effect right after the accepting edge
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h00C; req_wdata = 32'h0;
    m_route[3] = 2'b00;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check_eq("R8 fiq off after cfg write", 32'(fiq_out), 32'd0);

    // R7 ignored writes and unmapped reads
    src_in[63] = 1'b1;
    settle();
    bus_write(12'h104, 32'hFF);
    bus_read(12'h104, 32'h7F, "R7 selector write ignored");
    bus_write(12'h100, 32'h60);
    bus_read(12'h000, 32'h0, "R7 unmapped write no alias");
    bus_read(12'h100, 32'h0, "R7 unmapped read 0x100");
    bus_read(12'h200, 32'h0, "R7 unmapped read 0x200");

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    bus_read(12'h028, 32'h20, "R9 held response data");
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_eq("R9 rsp_valid held", 32'(rsp_valid), 32'd1);
    check_eq("R9 req_ready low", 32'(req_ready), 32'd0);
    check_eq("R9 data stable", rsp_rdata, 32'h20);
    rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    check_eq("R9 rsp_valid dropped", 32'(rsp_valid), 32'd0);
    finish_run();
  end
endmodule